// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital controller wrapped around a successive-approximation converter. Software programs it through a control write that carries a power bit, a repeat (continuous) bit and two interrupt enables. A hardware trigger pulse also starts conversions, and a select line beside it chooses whether the trigger asks for a regular or an injected conversion. After power-up the sequencer holds off all conversions for a programmable settling interval. It then runs fixed-length conversions, one at a time or back to back.

The analog core is modelled by a synchronous result bus. The sequencer samples that bus on the last clock of each conversion window. A regular result goes to the regular data register and an injected result goes to the injected data register. Each path has its own sticky completion flag, which software clears with a write strobe or by reading the matching data register. A single interrupt line combines both flags, each gated by its enable.

An injected request that arrives during a regular conversion waits and runs as soon as the current conversion ends. Clearing the power bit abandons all work at once.

Top module: `adc_seq`

## Requirements
- R1: After reset, both data registers read 0, both flags and `irq` are 0, `ready` and `busy` are 0, and `conv_inj` is 0.
- R2: A control write with `cfg_on`=1 while powered down starts a settling interval of STAB_CYC cycles, during which `ready`=0 and no conversion runs. Start requests made during that interval are kept and served once `ready` rises.
- R3: A control write with `cfg_on`=1 while powered up requests a regular conversion. The power-up write itself requests nothing. Triggers that arrive while powered down are ignored.
- R4: A `trig` pulse with `trig_inj`=1 requests an injected conversion, and with `trig_inj`=0 it requests a regular one. `conv_inj` shows the kind of the current or last conversion: 1 means injected.
- R5: A requested conversion starts on the second clock edge after the request when the sequencer is idle. `busy` then stays high for CONV_CYC (default 14) cycles, and `res_i` is sampled on the last edge of that window.
- R6: A finished regular conversion loads `reg_dr` with the sample and sets `reg_flag`.
- R7: A finished injected conversion loads `inj_dr` with the sample and sets `inj_flag`, and leaves `reg_dr` unchanged.
- R8: With the repeat bit clear, one conversion runs and then `busy` drops. With it set, the same kind of conversion restarts on the completion edge, so `busy` never drops.
- R9: When a conversion ends, a pending injected request is served first. After that come a repeat, then a pending regular request.
- R10: Each flag stays set until its clear strobe (`clr_reg_flag`/`clr_inj_flag`) or its read strobe (`rd_reg`/`rd_inj`) is applied. If a set and a clear fall in the same cycle, the set wins.
- R11: `irq` = (`reg_flag` AND regular enable) OR (`inj_flag` AND injected enable). The enables come from the latest control write.
- R12: A control write with `cfg_on`=0 drops `ready` and `busy` on the next cycle. It stores no result, sets no flag and discards pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_on | input | 1 | Power / start bit of the control write |
| cfg_cont | input | 1 | Repeat (continuous) bit of the control write |
| cfg_reg_irq_en | input | 1 | Regular interrupt enable of the control write |
| cfg_inj_irq_en | input | 1 | Injected interrupt enable of the control write |
| trig | input | 1 | External trigger pulse |
| trig_inj | input | 1 | Trigger kind: 1 injected, 0 regular |
| res_i | input | DW | Converter result bus |
| clr_reg_flag | input | 1 | Clear regular flag |
| clr_inj_flag | input | 1 | Clear injected flag |
| rd_reg | input | 1 | Regular data read strobe (clears its flag) |
| rd_inj | input | 1 | Injected data read strobe (clears its flag) |
| reg_dr | output | DW | Regular data register |
| inj_dr | output | DW | Injected data register |
| reg_flag | output | 1 | Regular end-of-conversion flag |
| inj_flag | output | 1 | Injected end-of-conversion flag |
| irq | output | 1 | Combined interrupt |
| ready | output | 1 | Powered and settled |
| busy | output | 1 | Conversion in progress |
| conv_inj | output | 1 | Kind of current or last conversion |

## Verification
The properties assume that every input is synchronous to `clk` and that strobes are one-cycle pulses. They also assume `res_i` is stable across the sampling edge. An abort may coincide with a final conversion cycle, and the properties accept this. The bench drives all inputs on the falling edge, one strobe per pulse, and changes `res_i` every cycle so that a sample taken one edge off is caught. A behavioural model checks every output on every cycle, and directed checks cover settling length, conversion length, queueing, repeat and abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_STAB = 2'd1,
    ST_IDLE = 2'd2,
    ST_CONV = 2'd3
  } seq_state_e;

  typedef enum logic {
    K_REG = 1'b0,
    K_INJ = 1'b1
  } conv_kind_e;
endpackage

// File: rtl/adc_seq_stab.sv
module adc_seq_stab #(
  parameter int STAB_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int SW = $clog2(STAB_CYC + 1);

  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (run) cnt_d = cnt_q + SW'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == SW'(STAB_CYC - 1));
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          flag
);
  logic flag_d;

  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '0;
    else if (set) dout <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_on,
  input  logic       cfg_cont,
  input  logic       cfg_reg_irq_en,
  input  logic       cfg_inj_irq_en,
  input  logic       trig,
  input  logic       trig_inj,
  input  logic       stab_done,
  output seq_state_e state,
  output conv_kind_e kind,
  output logic       stab_run,
  output logic       done_reg,
  output logic       done_inj,
  output logic       reg_ie,
  output logic       inj_ie
);
  localparam int CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;

  seq_state_e    state_d;
  conv_kind_e    kind_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_reg_q, pend_reg_d, pend_inj_q, pend_inj_d;
  logic          cont_q;
  logic          powered, abort, req_reg, req_inj, last, fin;
  logic          start_reg, start_inj;

  assign powered = (state != ST_OFF);
  assign abort   = cfg_we && !cfg_on;
  assign req_reg = powered && ((cfg_we && cfg_on) || (trig && !trig_inj));
  assign req_inj = powered && trig && trig_inj;
  assign last    = (state == ST_CONV) && (cnt_q == CW'(CONV_CYC - 1));
  assign fin     = last && !abort;

  always_comb begin
    state_d   = state;
    kind_d    = kind;
    cnt_d     = (state == ST_CONV) ? cnt_q + CW'(1) : '0;
    start_reg = 1'b0;
    start_inj = 1'b0;
    case (state)
      ST_OFF:  if (cfg_we && cfg_on) state_d = ST_STAB;
      ST_STAB: if (stab_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (pend_inj_q)      start_inj = 1'b1;
        else if (pend_reg_q) start_reg = 1'b1;
      end
      ST_CONV: begin
        if (last) begin
          if (pend_inj_q)      start_inj = 1'b1;
          else if (cont_q) begin
            if (kind == K_INJ) start_inj = 1'b1;
            else               start_reg = 1'b1;
          end
          else if (pend_reg_q) start_reg = 1'b1;
          else                 state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_OFF;
    endcase
    if (start_inj || start_reg) begin
      state_d = ST_CONV;
      cnt_d   = '0;
      kind_d  = start_inj ? K_INJ : K_REG;
    end
    if (abort) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end
  end

  always_comb begin
    pend_reg_d = abort ? 1'b0 : ((pend_reg_q && !start_reg) || req_reg);
    pend_inj_d = abort ? 1'b0 : ((pend_inj_q && !start_inj) || req_inj);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      kind       <= K_REG;
      cnt_q      <= '0;
      pend_reg_q <= 1'b0;
      pend_inj_q <= 1'b0;
    end else begin
      state      <= state_d;
      kind       <= kind_d;
      cnt_q      <= cnt_d;
      pend_reg_q <= pend_reg_d;
      pend_inj_q <= pend_inj_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      reg_ie <= 1'b0;
      inj_ie <= 1'b0;
    end else if (cfg_we) begin
      cont_q <= cfg_cont;
      reg_ie <= cfg_reg_irq_en;
      inj_ie <= cfg_inj_irq_en;
    end
  end

  assign stab_run = (state == ST_STAB);
  assign done_reg = fin && (kind == K_REG);
  assign done_inj = fin && (kind == K_INJ);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CONV_CYC = 14,
  parameter int STAB_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_on,
  input  logic          cfg_cont,
  input  logic          cfg_reg_irq_en,
  input  logic          cfg_inj_irq_en,
  input  logic          trig,
  input  logic          trig_inj,
  input  logic [DW-1:0] res_i,
  input  logic          clr_reg_flag,
  input  logic          clr_inj_flag,
  input  logic          rd_reg,
  input  logic          rd_inj,
  output logic [DW-1:0] reg_dr,
  output logic [DW-1:0] inj_dr,
  output logic          reg_flag,
  output logic          inj_flag,
  output logic          irq,
  output logic          ready,
  output logic          busy,
  output logic          conv_inj
);
  localparam int NPATH = 2;

  logic       rst_m, rst_s;
  seq_state_e state;
  conv_kind_e kind;
  logic       stab_run, stab_done, done_reg, done_inj, reg_ie, inj_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  adc_seq_stab #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk  (clk),
    .rst_n(rst_s),
    .run  (stab_run),
    .done (stab_done)
  );

  adc_seq_ctrl #(.CONV_CYC(CONV_CYC)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_s),
    .cfg_we        (cfg_we),
    .cfg_on        (cfg_on),
    .cfg_cont      (cfg_cont),
    .cfg_reg_irq_en(cfg_reg_irq_en),
    .cfg_inj_irq_en(cfg_inj_irq_en),
    .trig          (trig),
    .trig_inj      (trig_inj),
    .stab_done     (stab_done),
    .state         (state),
    .kind          (kind),
    .stab_run      (stab_run),
    .done_reg      (done_reg),
    .done_inj      (done_inj),
    .reg_ie        (reg_ie),
    .inj_ie        (inj_ie)
  );

  logic [NPATH-1:0] set_v, clr_v, flag_v;
  logic [DW-1:0]    dout_v [NPATH];

  assign set_v = {done_inj, done_reg};
  assign clr_v = {clr_inj_flag || rd_inj, clr_reg_flag || rd_reg};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    adc_seq_bank #(.DW(DW)) u_bank (
      .clk  (clk),
      .rst_n(rst_s),
      .set  (set_v[p]),
      .clr  (clr_v[p]),
      .din  (res_i),
      .dout (dout_v[p]),
      .flag (flag_v[p])
    );
  end

  assign reg_dr   = dout_v[0];
  assign inj_dr   = dout_v[1];
  assign reg_flag = flag_v[0];
  assign inj_flag = flag_v[1];
  assign irq      = (flag_v[0] && reg_ie) || (flag_v[1] && inj_ie);
  assign ready    = (state == ST_IDLE) || (state == ST_CONV);
  assign busy     = (state == ST_CONV);
  assign conv_inj = (kind == K_INJ);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DW       = 16,
  parameter int CONV_CYC = 14
) (
  input logic          clk,
  input logic          rst_s,
  input logic          cfg_we,
  input logic          cfg_on,
  input logic          busy,
  input logic          ready,
  input logic          reg_flag,
  input logic          inj_flag,
  input logic          irq,
  input logic [DW-1:0] reg_dr,
  input logic [DW-1:0] inj_dr,
  input logic [DW-1:0] res_i,
  input logic          done_reg,
  input logic          done_inj,
  input logic          clr_reg_flag,
  input logic          rd_reg
);
  localparam int KW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;

  logic [KW-1:0] k_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)                                 k_q <= '0;
    else if (!busy || k_q == KW'(CONV_CYC - 1)) k_q <= '0;
    else                                        k_q <= k_q + KW'(1);
  end

  a_r5_window_len: assert property (@(posedge clk) disable iff (!rst_s)
    (done_reg || done_inj) |-> (k_q == KW'(CONV_CYC - 1)));

  a_r6_reg_capture: assert property (@(posedge clk) disable iff (!rst_s)
    done_reg |=> (reg_flag && reg_dr == $past(res_i)));

  a_r7_inj_capture: assert property (@(posedge clk) disable iff (!rst_s)
    done_inj |=> (inj_flag && inj_dr == $past(res_i)));

  a_r7_reg_untouched: assert property (@(posedge clk) disable iff (!rst_s)
    done_inj |=> $stable(reg_dr));

  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_s)
    ((clr_reg_flag || rd_reg) && !done_reg) |=> !reg_flag);

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (!reg_flag && !inj_flag) |-> !irq);

  a_r12_abort_off: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_we && !cfg_on) |=> (!ready && !busy));
endmodule

bind adc_seq adc_seq_chk #(.DW(DW), .CONV_CYC(CONV_CYC)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .cfg_we      (cfg_we),
  .cfg_on      (cfg_on),
  .busy        (busy),
  .ready       (ready),
  .reg_flag    (reg_flag),
  .inj_flag    (inj_flag),
  .irq         (irq),
  .reg_dr      (reg_dr),
  .inj_dr      (inj_dr),
  .res_i       (res_i),
  .done_reg    (done_reg),
  .done_inj    (done_inj),
  .clr_reg_flag(clr_reg_flag),
  .rd_reg      (rd_reg)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
  localparam int DW = 16;
  localparam int CONV = 14;
  localparam int STAB = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_on = 0, cfg_cont = 0, cfg_rie = 0, cfg_iie = 0;
  logic trig = 0, trig_inj = 0;
  logic [DW-1:0] res_i = 16'h1234;
  logic clr_r = 0, clr_i = 0, rd_r = 0, rd_i = 0;
  logic [DW-1:0] reg_dr, inj_dr;
  logic reg_flag, inj_flag, irq, ready, busy, conv_inj;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_seq #(.DW(DW), .CONV_CYC(CONV), .STAB_CYC(STAB)) u_adc_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_on(cfg_on),
    .cfg_cont(cfg_cont), .cfg_reg_irq_en(cfg_rie), .cfg_inj_irq_en(cfg_iie),
    .trig(trig), .trig_inj(trig_inj), .res_i(res_i),
    .clr_reg_flag(clr_r), .clr_inj_flag(clr_i), .rd_reg(rd_r), .rd_inj(rd_i),
    .reg_dr(reg_dr), .inj_dr(inj_dr), .reg_flag(reg_flag), .inj_flag(inj_flag),
    .irq(irq), .ready(ready), .busy(busy), .conv_inj(conv_inj)
  );

  always @(negedge clk) res_i <= res_i + 16'h0d31;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model: 0 off, 1 settling, 2 idle, 3 converting
  int m_st, m_cnt, m_stc;
  bit m_r1, m_r2, m_kind, m_pr, m_pi, m_cont, m_rie, m_iie, m_rf, m_if;
  logic [DW-1:0] m_rdr, m_idr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_r2) begin
      m_st = 0; m_cnt = 0; m_stc = 0; m_kind = 0; m_pr = 0; m_pi = 0;
      m_cont = 0; m_rie = 0; m_iie = 0; m_rf = 0; m_if = 0;
      m_rdr = 0; m_idr = 0;
    end else begin
      bit on, ab, rq_r, rq_i, s_r, s_i, fin;
      int nst, ncnt, nstc;
      on   = (m_st != 0);
      ab   = cfg_we && !cfg_on;
      rq_r = on && ((cfg_we && cfg_on) || (trig && !trig_inj));
      rq_i = on && trig && trig_inj;
      s_r = 0; s_i = 0; fin = 0;
      nst  = m_st;
      ncnt = (m_st == 3) ? m_cnt + 1 : 0;
      nstc = (m_st == 1) ? m_stc + 1 : 0;
      if (m_st == 0 && cfg_we && cfg_on) nst = 1;
      if (m_st == 1 && m_stc == STAB - 1) nst = 2;
      if (m_st == 2) begin
        if (m_pi) s_i = 1; else if (m_pr) s_r = 1;
      end
      if (m_st == 3 && m_cnt == CONV - 1) begin
        fin = !ab;
        if (m_pi) s_i = 1;
        else if (m_cont) begin if (m_kind) s_i = 1; else s_r = 1; end
        else if (m_pr) s_r = 1;
        else nst = 2;
      end
      if (fin && !m_kind) m_rdr = res_i;
      if (fin && m_kind)  m_idr = res_i;
      m_rf = (fin && !m_kind) ? 1'b1 : ((clr_r || rd_r) ? 1'b0 : m_rf);
      m_if = (fin && m_kind)  ? 1'b1 : ((clr_i || rd_i) ? 1'b0 : m_if);
      if (s_i || s_r) begin nst = 3; ncnt = 0; m_kind = s_i; end
      if (ab) begin nst = 0; ncnt = 0; end
      m_pr = ab ? 1'b0 : ((m_pr && !s_r) || rq_r);
      m_pi = ab ? 1'b0 : ((m_pi && !s_i) || rq_i);
      if (cfg_we) begin m_cont = cfg_cont; m_rie = cfg_rie; m_iie = cfg_iie; end
      m_st = nst; m_cnt = ncnt; m_stc = nstc;
    end
    if (!rst_n) begin m_r1 = 0; m_r2 = 0; end
    else begin m_r2 = m_r1; m_r1 = 1; end
  end

  always @(negedge clk) begin
    if (m_r2) begin
      chk("R5 busy", busy, m_st == 3);
      chk("R2 ready", ready, m_st >= 2);
      chk("R4 conv_inj", conv_inj, m_kind);
      chk("R6 reg_dr", reg_dr, m_rdr);
      chk("R7 inj_dr", inj_dr, m_idr);
      chk("R10 reg_flag", reg_flag, m_rf);
      chk("R10 inj_flag", inj_flag, m_if);
      chk("R11 irq", irq, (m_rf && m_rie) || (m_if && m_iie));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit on, input bit cont, input bit rie, input bit iie);
    cfg_we = 1; cfg_on = on; cfg_cont = cont; cfg_rie = rie; cfg_iie = iie;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic trg(input bit inj);
    trig = 1; trig_inj = inj;
    @(negedge clk);
    trig = 0; trig_inj = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    logic [DW-1:0] keep;
    cyc(3);
    rst_n = 1;
    cyc(4);
    // R1 reset state
    chk("R1 reg_dr", reg_dr, 0); chk("R1 inj_dr", inj_dr, 0);
    chk("R1 flags", {reg_flag, inj_flag, irq}, 0);
    chk("R1 ready/busy", {ready, busy, conv_inj}, 0);

    // R3 trigger while powered down is ignored
    trg(0); trg(1); cyc(3);
    chk("R3 off trig busy", busy, 0);
    chk("R3 off trig ready", ready, 0);

    // R2 power-up with a request made during settling
    wr(1, 0, 1, 1);
    cyc(2);
    wr(1, 0, 1, 1);            // request held while settling
    n = 3;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    chk("R2 settle length", n, STAB);
    @(negedge clk);
    chk("R2 pending served", busy, 1);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R5 busy length", n, CONV);
    chk("R6 reg_flag set", reg_flag, 1);
    chk("R11 irq on", irq, 1);
    chk("R8 single stops", busy, 0);

    // R10 read strobe clears
    rd_r = 1; @(negedge clk); rd_r = 0;
    chk("R10 read clears", reg_flag, 0);

    // R4/R7 injected via trigger
    keep = reg_dr;
    trg(1); cyc(1);
    chk("R4 inj start", {busy, conv_inj}, 2'b11);
    wait_idle();
    chk("R7 inj_flag", inj_flag, 1);
    chk("R7 reg_dr kept", reg_dr, keep);
    clr_i = 1; @(negedge clk); clr_i = 0;
    chk("R10 clear strobe", inj_flag, 0);

    // R9 injected queued behind regular
    trg(0); cyc(5);
    trg(1);
    n = 0;
    while (!reg_flag && n < 100) begin n++; @(negedge clk); end
    chk("R9 inj follows", {busy, conv_inj}, 2'b11);
    wait_idle();
    chk("R9 inj done", inj_flag, 1);

    // R11 enables off: flags stay, irq low
    wr(1, 0, 0, 0);
    cyc(1); wait_idle();
    chk("R11 irq gated", irq, 0);
    chk("R11 flag still set", reg_flag, 1);

    // R8 continuous mode
    wr(1, 1, 1, 0);
    cyc(1);
    n = 0;
    for (int i = 0; i < 3 * CONV + 2; i++) begin
      if (busy) n++;
      @(negedge clk);
    end
    chk("R8 continuous busy", n, 3 * CONV + 2);

    // R12 abort
    cyc(4);
    keep = reg_dr;
    rd_r = 1; @(negedge clk); rd_r = 0;
    wr(0, 0, 1, 0);
    chk("R12 abort off", {ready, busy}, 2'b00);
    cyc(CONV + 2);
    chk("R12 no result", reg_dr, keep);
    chk("R12 no flag", reg_flag, 0);
    trg(0); cyc(3);
    chk("R12 off ignores trig", busy, 0);
    finish_run();
  end
endmodule